// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Flag Register

This block holds the status word and the interrupt flag of a two-wire serial bus controller. It watches the clock and data lines to keep a bus-busy flag, and it collects single-cycle event strobes from a separate byte engine: a finished byte, an address match, a general call match, a lost arbitration, the acknowledge bit seen after a sent byte, and the read/write bit of the calling address. Each flag has its own rule for setting and clearing.

Software reaches the block through a small register port with three selects: status, data and control. Reading status returns the flag word. Writing status clears only the arbitration-lost and interrupt-pending flags, and only at bit positions holding 1. Accesses to the data register clear the transfer-complete flag, in a direction that depends on the transfer mode. A write to the control register clears the addressed-as-slave flag and has no other effect. The data register holds the byte software wrote and drives it to the byte engine. A level interrupt is raised while the interrupt-pending flag and the enable input are both 1.

Top module: `i2c_stat_reg`

## Requirements
- R1: The status word, read with reg_sel=0, is {7 transfer complete, 6 addressed as slave, 5 bus busy, 4 arbitration lost, 3 always 0, 2 slave read/write, 1 interrupt pending, 0 received acknowledge}; reg_rdata shows the value in the cycle after the one in which reg_rd is high.
- R2: Transfer complete (bit 7) is set by ev_byte_done; it is cleared by a read of the data register (reg_sel=1) while tx_mode=0, or by a write of the data register while tx_mode=1. A data access in the other direction leaves it unchanged.
- R3: Addressed as slave (bit 6) is set by ev_addr_hit, or by ev_gcall_hit while gcall_en=1; ev_gcall_hit with gcall_en=0 has no effect on any flag. Any write with reg_sel=2 clears it.
- R4: Slave read/write (bit 2) takes ev_rw_bit in every cycle where an address match (as in R3) is accepted, and keeps it otherwise; 1 means slave transmit.
- R5: Received acknowledge (bit 0) takes ev_ack_bit in every cycle with ev_byte_done, and keeps it otherwise; 0 means an acknowledge was seen.
- R6: Arbitration lost (bit 4) is set by ev_arb_lost and cleared only by a status write with reg_wdata[4]=1; a status write leaves every other bit except bit 1 unchanged.
- R7: Interrupt pending (bit 1) is set by ev_byte_done, an accepted address match or ev_arb_lost, and cleared only by a status write with reg_wdata[1]=1.
- R8: When a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: Bus busy (bit 5) is set by a start (SDA falling while SCL is high) and cleared by a stop (SDA rising while SCL is high), both seen after a SYNC_STAGES-flop synchronizer; SDA changes while SCL is low leave it unchanged. It is visible in the status no later than four cycles after the line change.
- R10: irq is 1 in the cycle after a cycle with interrupt pending=1 and irq_en=1, and 0 in the cycle after any other cycle.
- R11: The data register resets to 0x00, loads reg_wdata on a write with reg_sel=1, drives tx_byte, and reads back with reg_sel=1.
- R12: A synchronous active-high rst clears every flag, the data register, reg_rdata and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sampled from the pad |
| sda_in | input | 1 | Bus data line as sampled from the pad |
| ev_byte_done | input | 1 | Strobe: byte transfer finished |
| ev_ack_bit | input | 1 | Acknowledge bit seen after a sent byte, valid with ev_byte_done |
| ev_addr_hit | input | 1 | Strobe: calling address equals own address |
| ev_gcall_hit | input | 1 | Strobe: general call address received |
| gcall_en | input | 1 | Accept general call as an address match |
| ev_rw_bit | input | 1 | Read/write bit of the calling address, valid with a match |
| ev_arb_lost | input | 1 | Strobe: arbitration lost |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| irq_en | input | 1 | Interrupt enable |
| reg_sel | input | 2 | Register select: 0 status, 1 data, 2 control, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| tx_byte | output | 8 | Data register contents toward the byte engine |
| irq | output | 1 | Level interrupt request |

## Verification
A flag stuck or cleared by the wrong access shows in the very next status read, two cycles after the stimulus, so every vector reads the full word right after it is applied and compares all eight bits at once. A wrong set-versus-clear priority shows as a zero where a one belongs in that same read, and is provoked by putting a strobe and a clear in one cycle. A faulty start or stop detector shows as a wrong bit 5 within four cycles of a line change, and a stale interrupt level shows on irq one cycle after the flag or the enable moves.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bit order here is the status word layout, MSB first.
  typedef struct packed {
    logic xfer_done;
    logic slv_addr;
    logic bus_busy;
    logic arb_lost;
    logic rsvd;
    logic slv_dir;
    logic int_pend;
    logic nack;
  } stat_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic line_d
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {DEPTH{RST_VAL}};
    else     sh <= {sh[DEPTH-2:0], line_in};
  end

  assign line_s = sh[STAGES-1];
  assign line_d = sh[STAGES];
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_high, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst(rst), .line_in(scl_in), .line_s(scl_s), .line_d(scl_d)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst(rst), .line_in(sda_in), .line_s(sda_s), .line_d(sda_d)
  );

  // SCL must be high on both sides of the SDA edge.
  assign scl_high  = scl_s & scl_d;
  assign start_det = scl_high & sda_d & ~sda_s;
  assign stop_det  = scl_high & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  // R9
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  // R9
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_high) |=> (busy == $past(busy)));
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
  import i2c_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ev_byte_done,
  input  logic  ev_ack_bit,
  input  logic  ev_addr_hit,
  input  logic  ev_gcall_hit,
  input  logic  gcall_en,
  input  logic  ev_rw_bit,
  input  logic  ev_arb_lost,
  input  logic  tx_mode,
  input  logic  data_rd,
  input  logic  data_wr,
  input  logic  ctrl_wr,
  input  logic  clr_arb,
  input  logic  clr_int,
  input  logic  bus_busy,
  output stat_t stat
);
  logic xfer_q, slv_q, arb_q, dir_q, int_q, nack_q;
  logic addr_match, xfer_clr, int_set;

  assign addr_match = ev_addr_hit | (ev_gcall_hit & gcall_en);
  assign xfer_clr   = (data_rd & ~tx_mode) | (data_wr & tx_mode);
  assign int_set    = ev_byte_done | addr_match | ev_arb_lost;

  // Every flag: set has priority over clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= 1'b0;
      slv_q  <= 1'b0;
      arb_q  <= 1'b0;
      dir_q  <= 1'b0;
      int_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (ev_byte_done)  xfer_q <= 1'b1;
      else if (xfer_clr) xfer_q <= 1'b0;

      if (addr_match)    slv_q <= 1'b1;
      else if (ctrl_wr)  slv_q <= 1'b0;

      if (ev_arb_lost)   arb_q <= 1'b1;
      else if (clr_arb)  arb_q <= 1'b0;

      if (int_set)       int_q <= 1'b1;
      else if (clr_int)  int_q <= 1'b0;

      if (addr_match)    dir_q  <= ev_rw_bit;
      if (ev_byte_done)  nack_q <= ev_ack_bit;
    end
  end

  always_comb begin
    stat           = '0;
    stat.xfer_done = xfer_q;
    stat.slv_addr  = slv_q;
    stat.bus_busy  = bus_busy;
    stat.arb_lost  = arb_q;
    stat.slv_dir   = dir_q;
    stat.int_pend  = int_q;
    stat.nack      = nack_q;
  end

  // R2
  xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_q && !xfer_clr) |=> xfer_q);
  // R3
  slv_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ev_addr_hit && !(ev_gcall_hit && gcall_en)) |=> !slv_q);
  // R6
  arb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_q && !clr_arb) |=> arb_q);
  // R8
  arb_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> arb_q);
  // R7
  int_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_byte_done || ev_addr_hit || ev_arb_lost) |=> int_q);
  // R5
  nack_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_byte_done) |=> $stable(nack_q));
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ev_byte_done,
  input  logic              ev_ack_bit,
  input  logic              ev_addr_hit,
  input  logic              ev_gcall_hit,
  input  logic              gcall_en,
  input  logic              ev_rw_bit,
  input  logic              ev_arb_lost,
  input  logic              tx_mode,
  input  logic              irq_en,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] tx_byte,
  output logic              irq
);
  localparam int ARB_BIT = 4;
  localparam int INT_BIT = 1;

  reg_sel_e          sel;
  logic              busy;
  logic              stat_wr, data_wr, data_rd, ctrl_wr;
  stat_t             stat;
  logic [DATA_W-1:0] data_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign stat_wr = reg_wr & (sel == SEL_STAT);
  assign data_wr = reg_wr & (sel == SEL_DATA);
  assign data_rd = reg_rd & (sel == SEL_DATA);
  assign ctrl_wr = reg_wr & (sel == SEL_CTRL);

  i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
  );

  i2c_flag_bank u_flags (
    .clk(clk), .rst(rst),
    .ev_byte_done(ev_byte_done), .ev_ack_bit(ev_ack_bit),
    .ev_addr_hit(ev_addr_hit), .ev_gcall_hit(ev_gcall_hit),
    .gcall_en(gcall_en), .ev_rw_bit(ev_rw_bit), .ev_arb_lost(ev_arb_lost),
    .tx_mode(tx_mode), .data_rd(data_rd), .data_wr(data_wr),
    .ctrl_wr(ctrl_wr),
    .clr_arb(stat_wr & reg_wdata[ARB_BIT]),
    .clr_int(stat_wr & reg_wdata[INT_BIT]),
    .bus_busy(busy), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (data_wr) data_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_STAT: reg_rdata <= stat;
        SEL_DATA: reg_rdata <= data_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= stat.int_pend & irq_en;
  end

  assign tx_byte = data_q;

  // R10
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (stat.int_pend && irq_en) |=> irq);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat.int_pend || !irq_en) |=> !irq);
  // R11
  data_load_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (tx_byte == $past(reg_wdata)));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_STAT) |=> !reg_rdata[3]);
endmodule

// File: tb/sim_i2c_stat_reg.sv
module sim_i2c_stat_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       ev_byte_done = 0, ev_ack_bit = 0, ev_addr_hit = 0;
  logic       ev_gcall_hit = 0, gcall_en = 0, ev_rw_bit = 0, ev_arb_lost = 0;
  logic       tx_mode = 0, irq_en = 0;
  logic [1:0] reg_sel = 2'd3;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, tx_byte;
  logic       irq;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  i2c_stat_reg u0 (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .ev_byte_done(ev_byte_done), .ev_ack_bit(ev_ack_bit),
    .ev_addr_hit(ev_addr_hit), .ev_gcall_hit(ev_gcall_hit),
    .gcall_en(gcall_en), .ev_rw_bit(ev_rw_bit), .ev_arb_lost(ev_arb_lost),
    .tx_mode(tx_mode), .irq_en(irq_en), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_byte(tx_byte), .irq(irq)
  );

  // Vector: [31:24] {byte_done, addr_hit, gcall_hit, gcall_en, arb_lost,
  // ack_bit, rw_bit, tx_mode}; [23:21] op (0 none, 1 status write,
  // 2 data read, 3 data write, 4 control write); [15:8] wdata;
  // [7:0] expected status word.
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    32'h84_00_00_83, 32'h00_20_02_81, 32'h01_40_00_81, 32'h01_60_A5_01,
    32'h42_00_00_47, 32'h00_80_00_07, 32'h00_20_FF_05, 32'h20_00_00_05,
    32'h30_00_00_43, 32'h08_00_00_53, 32'h00_20_10_43, 32'h08_20_12_53,
    32'h80_40_00_D2, 32'h00_40_00_52, 32'h00_20_12_40, 32'h00_80_00_00
  };

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ev_byte_done = 0; ev_addr_hit = 0; ev_gcall_hit = 0; ev_arb_lost = 0;
    reg_wr = 0; reg_rd = 0; reg_sel = 2'd3;
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1; reg_wr = 1'b0;
    @(negedge clk);
    quiet();
    v = reg_rdata;
  endtask

  task automatic set_lines(input logic c, input logic d);
    @(negedge clk);
    scl_in = c; sda_in = d;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 and R11: reset state
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
    check("R11 tx_byte after reset", tx_byte, 8'h00);
    read_reg(2'd0, v); check("R12 status after reset", v, 8'h00);
    read_reg(2'd1, v); check("R11 data after reset", v, 8'h00);

    // R2 R3 R4 R5 R6 R7 R8 and R1: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      w = VEC[i];
      @(negedge clk);
      {ev_byte_done, ev_addr_hit, ev_gcall_hit, gcall_en,
       ev_arb_lost, ev_ack_bit, ev_rw_bit, tx_mode} = w[31:24];
      reg_wdata = w[15:8];
      case (w[23:21])
        3'd1: begin reg_sel = 2'd0; reg_wr = 1; end
        3'd2: begin reg_sel = 2'd1; reg_rd = 1; end
        3'd3: begin reg_sel = 2'd1; reg_wr = 1; end
        3'd4: begin reg_sel = 2'd2; reg_wr = 1; end
        default: ;
      endcase
      @(negedge clk);
      quiet();
      read_reg(2'd0, v);
      check($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7 R8)", i), v, w[7:0]);
    end

    // R11: data written in vector 3 reads back and drives tx_byte
    read_reg(2'd1, v); check("R11 data readback", v, 8'hA5);
    check("R11 tx_byte", tx_byte, 8'hA5);
    read_reg(2'd2, v); check("R1 control select reads zero", v, 8'h00);

    // R9: start, SDA wiggle with SCL low, stop
    set_lines(1'b1, 1'b0);
    read_reg(2'd0, v); check("R9 busy after start", v, 8'h20);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    set_lines(1'b0, 1'b0);
    set_lines(1'b1, 1'b0);
    read_reg(2'd0, v); check("R9 busy kept while SCL low", v, 8'h20);
    set_lines(1'b1, 1'b1);
    read_reg(2'd0, v); check("R9 idle after stop", v, 8'h00);
    set_lines(1'b0, 1'b1);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
    read_reg(2'd0, v); check("R9 no start with SCL low", v, 8'h00);
    set_lines(1'b1, 1'b1);

    // R10: level interrupt
    @(negedge clk); irq_en = 1'b1; ev_byte_done = 1'b1; ev_ack_bit = 1'b0;
    @(negedge clk); quiet();
    @(negedge clk);
    check("R10 irq raised", {7'd0, irq}, 8'h01);
    irq_en = 1'b0;
    @(negedge clk);
    check("R10 irq dropped with enable", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    @(negedge clk); reg_sel = 2'd0; reg_wr = 1; reg_wdata = 8'h02;
    @(negedge clk); quiet();
    @(negedge clk);
    check("R10 irq dropped after flag clear", {7'd0, irq}, 8'h00);

    // R12: reset in mid-run clears flags and data
    @(negedge clk); ev_arb_lost = 1'b1; reg_sel = 2'd1; reg_wr = 1;
    reg_wdata = 8'h3C;
    @(negedge clk); quiet();
    read_reg(2'd0, v); check("R6 arbitration flag set", v, 8'h92);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R12 irq after mid reset", {7'd0, irq}, 8'h00);
    read_reg(2'd0, v); check("R12 status after mid reset", v, 8'h00);
    read_reg(2'd1, v); check("R12 data after mid reset", v, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule